// File: doc/BRIEF.md
# Compare Match Interval Timer

A 32-bit interval timer with two clock domains. Software on a bus clock writes a compare value and a control word. The counter runs on a separate count clock. It advances on prescaled ticks, returns to zero after it reaches the compare value, and at each return sets an interrupt flag. When the interrupt mode is on, the flag drives a level interrupt until software clears it.

Control and compare writes are held in bus-domain registers. They are then carried into the count domain through a toggle handshake with a fixed minimum delay: five bus cycles on the bus side, then five count cycles after synchronisation. Until the update is acknowledged, later control or compare writes are dropped. The running count is returned to the bus side as a snapshot through a toggle handshake, so a read always gives one coherent value.

Top module: `cmt_timer`

## Requirements
- R1: After reset the compare register reads 0xFFFFFFFF, the control register reads 0, the count reads 0 and irq is low.
- R2: Word offsets: 0x0 gives the count (read only), 0x4 the compare value, 0x8 the control word and 0xC is write-only clear. Control bits: [6:4] clock select, [2] interrupt mode, [1] counter enable, [0] operation enable. Compare and control read back the last accepted write; reserved control bits read 0.
- R3: The counter runs only while control bits 1 and 0 are both set. Otherwise the count is held at 0, and writing a word with both bits clear stops the timer and resets the count.
- R4: On each tick the count increments. A tick that finds the count equal to the compare value loads 0 and sets the flag, so flag events occur every (compare+1)·2^sel count-clock cycles.
- R5: A clock select of n gives one tick every 2^n count-clock cycles (n = 0..7).
- R6: irq equals the flag while interrupt mode is 1 and stays high until cleared. With mode 0, irq is low but counting and wrapping continue, and a flag set meanwhile appears on irq once mode is set.
- R7: Writing 0xC with bit 0 = 1 clears the flag. Writing it with bit 0 = 0 has no effect.
- R8: A control or compare write reaches the count domain no sooner than 5 bus-clock plus 5 count-clock periods after it is accepted. Control or compare writes that arrive before that update is acknowledged are ignored.
- R9: Count reads are coherent snapshots. With the timer running they never go backwards within a period and never exceed the compare value.
- R10: Any compare value from 0 to 0xFFFFFFFF is accepted. Applying a new setting restarts the count and the prescaler from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register interface clock |
| bus_rst_n | input | 1 | Asynchronous active-low reset, bus domain |
| cnt_clk | input | 1 | Count clock |
| cnt_rst_n | input | 1 | Asynchronous active-low reset, count domain |
| bus_wr | input | 1 | Write strobe, one bus cycle per write |
| bus_addr | input | 4 | Byte offset; bits [3:2] select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Level interrupt, count-clock domain |

## Verification
Register read-back is sampled one nanosecond after the address settles. Count and configuration results are read only after a settle window of forty bus cycles, which is longer than the worst transfer and acknowledge path. Interrupt periods are measured in count-clock cycles between two rising edges of irq, each seen at a falling count-clock edge, so the fixed synchroniser delay cancels out of the difference. The transfer latency is checked as a lower bound: the time from the accepted start write to the first irq edge must be at least five periods of each clock.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
    localparam int SEL_W = 3;

    // word index decoded from address bits [3:2]
    localparam logic [1:0] W_COUNT = 2'd0;
    localparam logic [1:0] W_CMP   = 2'd1;
    localparam logic [1:0] W_CTRL  = 2'd2;
    localparam logic [1:0] W_CLR   = 2'd3;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             rsv;
        logic             mode;
        logic             cnt_en;
        logic             op_en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/cmt_sync.sv
module cmt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] pipe_q, pipe_d;

    always_comb begin
        pipe_d = {pipe_q[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/cmt_regs.sv
module cmt_regs
    import cmt_pkg::*;
#(
    parameter int DW      = 32,
    parameter int BUS_DLY = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [3:0]    addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o,
    output ctrl_t         cfg_ctrl_o,
    output logic [DW-1:0] cfg_cmp_o,
    output logic          req_tgl_o,
    input  logic          ack_tgl_i,
    output logic          clr_tgl_o,
    input  logic [DW-1:0] snap_i,
    input  logic          snap_tgl_i,
    output logic          snap_ack_o
);
    localparam int DLYW = $clog2(BUS_DLY + 1);

    typedef struct packed {
        ctrl_t         ctrl;
        logic [DW-1:0] cmp;
        logic          busy;
        logic          sent;
        logic [DLYW-1:0] dly;
        logic          req_tgl;
        logic          clr_tgl;
        logic          snap_ack;
        logic [DW-1:0] cnt;
    } regs_t;

    regs_t r_q, r_d;
    logic  ack_s, snap_s;
    logic [1:0] word;

    cmt_sync u_ack_sync  (.clk(clk), .rst_n(rst_n), .d_i(ack_tgl_i),  .q_o(ack_s));
    cmt_sync u_snap_sync (.clk(clk), .rst_n(rst_n), .d_i(snap_tgl_i), .q_o(snap_s));

    assign word = addr_i[3:2];

    always_comb begin
        r_d = r_q;
        if (wr_i) begin
            if (!r_q.busy && word == W_CMP) begin
                r_d.cmp  = wdata_i;
                r_d.busy = 1'b1;
                r_d.dly  = DLYW'(BUS_DLY);
            end
            if (!r_q.busy && word == W_CTRL) begin
                r_d.ctrl     = ctrl_t'(wdata_i[CTRL_W-1:0]);
                r_d.ctrl.rsv = 1'b0;
                r_d.busy     = 1'b1;
                r_d.dly      = DLYW'(BUS_DLY);
            end
            if (word == W_CLR && wdata_i[0]) r_d.clr_tgl = ~r_q.clr_tgl;
        end
        if (r_q.busy) begin
            if (r_q.dly != '0) begin
                r_d.dly = r_q.dly - 1'b1;
            end else if (!r_q.sent) begin
                r_d.sent    = 1'b1;
                r_d.req_tgl = ~r_q.req_tgl;
            end else if (ack_s == r_q.req_tgl) begin
                r_d.busy = 1'b0;
                r_d.sent = 1'b0;
            end
        end
        if (snap_s != r_q.snap_ack) begin
            r_d.cnt      = snap_i;
            r_d.snap_ack = snap_s;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.cmp <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        unique case (word)
            W_COUNT: rdata_o = r_q.cnt;
            W_CMP:   rdata_o = r_q.cmp;
            W_CTRL:  rdata_o = {{(DW-CTRL_W){1'b0}}, r_q.ctrl};
            default: rdata_o = '0;
        endcase
    end

    assign cfg_ctrl_o = r_q.ctrl;
    assign cfg_cmp_o  = r_q.cmp;
    assign req_tgl_o  = r_q.req_tgl;
    assign clr_tgl_o  = r_q.clr_tgl;
    assign snap_ack_o = r_q.snap_ack;

    // R8: a compare write that lands while busy leaves the shadow untouched
    assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.busy && wr_i && word == W_CMP) |=> $stable(r_q.cmp));

    // R8: the request toggle never moves while the bus-side delay is running
    assert_req_after_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.dly != '0) |=> $stable(r_q.req_tgl));
endmodule

// File: rtl/cmt_core.sv
module cmt_core
    import cmt_pkg::*;
#(
    parameter int DW      = 32,
    parameter int CNT_DLY = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  ctrl_t         cfg_ctrl_i,
    input  logic [DW-1:0] cfg_cmp_i,
    input  logic          req_tgl_i,
    output logic          ack_tgl_o,
    input  logic          clr_tgl_i,
    output logic [DW-1:0] snap_o,
    output logic          snap_tgl_o,
    input  logic          snap_ack_i,
    output logic          irq_o
);
    localparam int PRE_W = (1 << SEL_W) - 1;
    localparam int DLYW  = $clog2(CNT_DLY + 1);

    typedef struct packed {
        ctrl_t           ctrl;
        logic [DW-1:0]   cmp;
        logic            pend;
        logic [DLYW-1:0] dly;
        logic            ack;
        logic [PRE_W-1:0] pre;
        logic [DW-1:0]   cnt;
        logic            flag;
        logic            clr_seen;
        logic [DW-1:0]   snap;
        logic            snap_tgl;
    } core_t;

    core_t c_q, c_d;
    logic  req_s, clr_s, sack_s;
    logic  run, tick;
    logic [PRE_W-1:0] mask;

    cmt_sync u_req_sync  (.clk(clk), .rst_n(rst_n), .d_i(req_tgl_i),  .q_o(req_s));
    cmt_sync u_clr_sync  (.clk(clk), .rst_n(rst_n), .d_i(clr_tgl_i),  .q_o(clr_s));
    cmt_sync u_sack_sync (.clk(clk), .rst_n(rst_n), .d_i(snap_ack_i), .q_o(sack_s));

    always_comb begin
        for (int i = 0; i < PRE_W; i++) mask[i] = (i < int'(c_q.ctrl.sel));
        run  = c_q.ctrl.cnt_en & c_q.ctrl.op_en;
        tick = run && ((c_q.pre & mask) == mask);

        c_d = c_q;
        // counting
        if (!run) begin
            c_d.pre = '0;
            c_d.cnt = '0;
        end else begin
            c_d.pre = c_q.pre + 1'b1;
            if (tick) c_d.cnt = (c_q.cnt == c_q.cmp) ? '0 : c_q.cnt + 1'b1;
        end
        // flag: clear first, wrap wins in the same cycle
        if (clr_s != c_q.clr_seen) begin
            c_d.clr_seen = clr_s;
            c_d.flag     = 1'b0;
        end
        if (tick && c_q.cnt == c_q.cmp) c_d.flag = 1'b1;
        // configuration transfer
        if (req_s != c_q.ack && !c_q.pend) begin
            c_d.pend = 1'b1;
            c_d.dly  = DLYW'(CNT_DLY);
        end
        if (c_q.pend) begin
            if (c_q.dly != '0) begin
                c_d.dly = c_q.dly - 1'b1;
            end else begin
                c_d.ctrl = cfg_ctrl_i;
                c_d.cmp  = cfg_cmp_i;
                c_d.ack  = ~c_q.ack;
                c_d.pend = 1'b0;
                c_d.cnt  = '0;
                c_d.pre  = '0;
            end
        end
        // count snapshot toward the bus side
        if (sack_s == c_q.snap_tgl) begin
            c_d.snap     = c_q.cnt;
            c_d.snap_tgl = ~c_q.snap_tgl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q     <= '0;
            c_q.cmp <= '1;
        end else begin
            c_q <= c_d;
        end
    end

    assign ack_tgl_o  = c_q.ack;
    assign snap_o     = c_q.snap;
    assign snap_tgl_o = c_q.snap_tgl;
    assign irq_o      = c_q.flag & c_q.ctrl.mode;

    assert_cnt_le_cmp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.cnt <= c_q.cmp);

    assert_stop_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (c_q.cnt == '0));

    assert_flag_on_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(c_q.flag) |-> $past(c_q.cnt == c_q.cmp));

    // R9: a nonzero count only ever holds or steps by one
    assert_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.cnt != '0) |-> (c_q.cnt == $past(c_q.cnt) || c_q.cnt == $past(c_q.cnt) + 1'b1));
endmodule

// File: rtl/cmt_timer.sv
module cmt_timer
    import cmt_pkg::*;
#(
    parameter int DW      = 32,
    parameter int BUS_DLY = 5,
    parameter int CNT_DLY = 5
) (
    input  logic          bus_clk,
    input  logic          bus_rst_n,
    input  logic          cnt_clk,
    input  logic          cnt_rst_n,
    input  logic          bus_wr,
    input  logic [3:0]    bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq
);
    ctrl_t         cfg_ctrl;
    logic [DW-1:0] cfg_cmp, snap;
    logic          req_tgl, ack_tgl, clr_tgl, snap_tgl, snap_ack;

    cmt_regs #(.DW(DW), .BUS_DLY(BUS_DLY)) u_regs (
        .clk(bus_clk), .rst_n(bus_rst_n),
        .wr_i(bus_wr), .addr_i(bus_addr), .wdata_i(bus_wdata), .rdata_o(bus_rdata),
        .cfg_ctrl_o(cfg_ctrl), .cfg_cmp_o(cfg_cmp),
        .req_tgl_o(req_tgl), .ack_tgl_i(ack_tgl), .clr_tgl_o(clr_tgl),
        .snap_i(snap), .snap_tgl_i(snap_tgl), .snap_ack_o(snap_ack)
    );

    cmt_core #(.DW(DW), .CNT_DLY(CNT_DLY)) u_core (
        .clk(cnt_clk), .rst_n(cnt_rst_n),
        .cfg_ctrl_i(cfg_ctrl), .cfg_cmp_i(cfg_cmp),
        .req_tgl_i(req_tgl), .ack_tgl_o(ack_tgl), .clr_tgl_i(clr_tgl),
        .snap_o(snap), .snap_tgl_o(snap_tgl), .snap_ack_i(snap_ack),
        .irq_o(irq)
    );
endmodule

// File: tb/cmt_timer_tb.sv
module cmt_timer_tb;
    localparam int BUS_T = 10;
    localparam int CNT_T = 14;

    logic        bus_clk = 0, cnt_clk = 0;
    logic        bus_rst_n = 0, cnt_rst_n = 0;
    logic        bus_wr = 0;
    logic [3:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic        irq;

    int total = 0, bad = 0;
    bit done = 0;
    int cyc = 0;
    int rise_n = 0, rise_cyc = 0;
    time rise_t = 0, wr_t = 0;
    logic irq_prev = 0;

    always #(BUS_T/2) bus_clk = ~bus_clk;
    always #(CNT_T/2) cnt_clk = ~cnt_clk;

    cmt_timer u_dut (
        .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .cnt_clk(cnt_clk), .cnt_rst_n(cnt_rst_n),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    always @(posedge cnt_clk) cyc <= cyc + 1;
    always @(negedge cnt_clk) begin
        if (irq && !irq_prev) begin
            rise_cyc = cyc;
            rise_t   = $time;
            rise_n++;
        end
        irq_prev = irq;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge bus_clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge bus_clk);
        wr_t = $time;
        @(negedge bus_clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge bus_clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic settle();
        repeat (40) @(posedge bus_clk);
    endtask

    task automatic wait_rise(output bit ok);
        int n0 = rise_n;
        ok = 0;
        for (int i = 0; i < 5000; i++) begin
            @(negedge cnt_clk);
            if (rise_n != n0) begin ok = 1; break; end
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(4'h4, v); chk(v == 32'hFFFF_FFFF, "R1 compare", v, 32'hFFFF_FFFF);
        rd(4'h8, v); chk(v == 0, "R1 control", v, 0);
        rd(4'h0, v); chk(v == 0, "R1 count", v, 0);
        chk(irq == 0, "R1 irq", irq, 0);
    endtask

    task automatic t_latency();
        bit ok; time t0;
        wr(4'h4, 0);          // R10: compare of 0 wraps on every tick
        settle();
        wr(4'h8, 32'h07);
        t0 = wr_t;
        wait_rise(ok);
        chk(ok && (rise_t - t0) >= 5*BUS_T + 5*CNT_T, "R8 latency",
            longint'(rise_t - t0), 5*BUS_T + 5*CNT_T);
        repeat (10) @(posedge bus_clk);
        @(negedge bus_clk);
        chk(irq == 1, "R6 level held", irq, 1);
        wr(4'h8, 0);
        settle();
        wr(4'hC, 1);
        settle();
    endtask

    task automatic t_busy();
        logic [31:0] v;
        wr(4'h4, 9);
        wr(4'h4, 123);        // arrives during busy window
        settle();
        rd(4'h4, v); chk(v == 9, "R8 ignored write", v, 9);
        wr(4'h8, 32'hFF);
        settle();
        rd(4'h8, v); chk(v == 32'h77, "R2 control readback", v, 32'h77);
        wr(4'h8, 0);
        settle();
    endtask

    task automatic t_period(input logic [31:0] cmp, input logic [2:0] sel, input int exp, input string req);
        bit ok1, ok2; int a;
        wr(4'h4, cmp);
        settle();
        wr(4'h8, {25'd0, sel, 4'b0111});
        settle();
        wr(4'hC, 1);
        wait_rise(ok1);
        a = rise_cyc;
        wr(4'hC, 1);
        wait_rise(ok2);
        chk(ok1 && ok2 && (rise_cyc - a) == exp, req, rise_cyc - a, exp);
    endtask

    task automatic t_clear();
        logic [31:0] v;
        wr(4'h8, 32'h05);     // mode on, only one enable bit
        settle();
        @(negedge bus_clk);
        chk(irq == 1, "R6 flag kept while halted", irq, 1);
        rd(4'h0, v); chk(v == 0, "R3 single enable halts", v, 0);
        wr(4'hC, 0);
        settle();
        @(negedge bus_clk);
        chk(irq == 1, "R7 zero write no effect", irq, 1);
        wr(4'hC, 1);
        settle();
        @(negedge bus_clk);
        chk(irq == 0, "R7 clear", irq, 0);
        wr(4'h8, 32'h06);
        settle();
        rd(4'h0, v); chk(v == 0, "R3 other enable alone halts", v, 0);
    endtask

    task automatic t_masked();
        logic [31:0] v; bit low = 1; bit inrange = 1;
        wr(4'h4, 5);
        settle();
        wr(4'h8, 32'h03);
        settle();
        for (int i = 0; i < 20; i++) begin
            repeat (5) @(posedge bus_clk);
            @(negedge bus_clk);
            if (irq) low = 0;
            rd(4'h0, v);
            if (v > 5) inrange = 0;
        end
        chk(low, "R6 masked irq low", !low, 0);
        chk(inrange, "R9 count within compare", !inrange, 0);
        wr(4'h8, 32'h07);
        settle();
        @(negedge bus_clk);
        chk(irq == 1, "R6 flag shown after unmask", irq, 1);
        wr(4'h8, 0);
        settle();
        wr(4'hC, 1);
        settle();
    endtask

    task automatic t_monotonic();
        logic [31:0] v, prev; bit mono = 1;
        wr(4'h4, 32'hFFFF_FFFF);
        settle();
        wr(4'h8, 32'h07);
        settle();
        rd(4'h0, prev);
        for (int i = 0; i < 5; i++) begin
            repeat (10) @(posedge bus_clk);
            rd(4'h0, v);
            if (v <= prev) mono = 0;
            prev = v;
        end
        chk(mono, "R9 monotonic reads", prev, 0);
        wr(4'h8, 32'h50);
        settle();
        rd(4'h0, v); chk(v == 0, "R3 stop resets count", v, 0);
        rd(4'h8, v); chk(v == 32'h50, "R2 select kept on stop", v, 32'h50);
    endtask

    initial begin
        repeat (3) @(posedge bus_clk);
        bus_rst_n = 1; cnt_rst_n = 1;
        repeat (3) @(posedge bus_clk);
        t_reset();
        t_latency();
        t_busy();
        t_period(9, 3'd0, 10, "R4 period sel0");
        t_period(4, 3'd2, 20, "R5 period sel2");
        t_period(1, 3'd3, 16, "R5 period sel3");
        t_clear();
        t_masked();
        t_monotonic();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule